// File: doc/BRIEF.md
# I2C Event Flags and Interrupt Request

This block sits between the protocol engine of an I2C controller and the processor. The engine raises one-cycle pulses for seven events: a received byte ready to read, a free transmit slot, a detected stop condition, a reload point in a long transfer, the end of a transfer, an address match and a received NACK. Each pulse is latched into a sticky status flag.

Every flag is cleared by its own action on a small register bus. Reading the receive data word clears the receive flag. Writing the transmit data word clears the transmit flag. Three flags clear when a 1 is written to their own bit in a clear register. The reload flag clears when a nonzero byte count is written. The completion flag clears when a start or stop command is written. A six-bit enable register masks the flags. The reload and completion flags share one enable bit. The masked flags are ORed into a single registered interrupt line.

The receive flag also drives a DMA request directly, so reception can be served without the receive interrupt enabled.

Top module: `i2c_evt_irq`

## Requirements
- R1: While reset is high, and on the cycle after it, every flag, every enable bit, `irq_o`, `tx_wr_o` and `rx_dma_req_o` are zero.
- R2: An event pulse on `evt_i[k]` sets flag k at the next clock edge. A bus read of address 3 returns the flags in bits 6:0 (bit 0 receive, 1 transmit, 2 stop, 3 reload, 4 completion, 5 address match, 6 NACK), and such a read changes no flag.
- R3: A bus read of address 4 returns `rx_data_i` in bits 7:0 and clears the receive flag at that edge.
- R4: A bus write to address 5 clears the transmit flag. On the next cycle it presents `reg_wdata[7:0]` on `tx_data_o`, with `tx_wr_o` high for exactly one cycle.
- R5: A write to address 2 clears the stop flag if bit 0 is 1, the address-match flag if bit 1 is 1, and the NACK flag if bit 2 is 1. Zero bits have no effect.
- R6: A write to address 1 with a nonzero count in bits 7:0 clears the reload flag. A count of zero leaves it set.
- R7: A write to address 1 with bit 8 (start) or bit 9 (stop) set clears the completion flag.
- R8: Address 0 holds the enables: bit 0 receive, 1 transmit, 2 stop, 3 transfer-complete (reload and completion), 4 address match, 5 NACK. A write stores bits 5:0 and a read returns them.
- R9: `irq_o` is the registered OR of every flag ANDed with its enable. It changes one clock after the flag or enable change that causes it.
- R10: If a flag's set event and its clear action fall in the same cycle, the flag ends up set.
- R11: `rx_dma_req_o` is high whenever the receive flag is set, whatever the receive enable is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 7 | Event pulses from the protocol engine, one bit per flag |
| reg_en | input | 1 | Bus access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 10 | Write data |
| reg_rdata | output | 10 | Read data, valid in the access cycle |
| rx_data_i | input | 8 | Received byte presented by the engine |
| tx_data_o | output | 8 | Byte handed to the engine |
| tx_wr_o | output | 1 | One-cycle strobe that tx_data_o is new |
| rx_dma_req_o | output | 1 | DMA request for a received byte |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A flag cell stuck or cleared by the wrong access appears at the status word on the very next read. It also shows on `irq_o` one cycle after that, once the matching enable is on. A wrong clear decode shows as a flag that is dropped or kept at the next status read, for example a zero byte count that clears the reload flag. A wrong priority between set and clear shows as a lost event in the same-cycle cases. A wrong enable mapping, such as the shared transfer-complete bit covering only one flag, shows as `irq_o` staying low two cycles after the stimulus.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;

    localparam int NUM_FLAGS     = 7;
    localparam int NUM_EN        = 6;
    localparam int BYTE_W        = 8;
    localparam int COUNT_W       = 8;
    localparam int CMD_START_BIT = COUNT_W;
    localparam int CMD_STOP_BIT  = COUNT_W + 1;
    localparam int BUS_DW        = CMD_STOP_BIT + 1;
    localparam int REG_AW        = 3;

    // Flag positions; also the bit order of the status word
    typedef enum int unsigned {
        FL_RX     = 0,
        FL_TX     = 1,
        FL_STOP   = 2,
        FL_RELOAD = 3,
        FL_DONE   = 4,
        FL_ADDR   = 5,
        FL_NACK   = 6
    } flag_e;

    // Enable bit positions
    typedef enum int unsigned {
        EN_RX   = 0,
        EN_TX   = 1,
        EN_STOP = 2,
        EN_TC   = 3,
        EN_ADDR = 4,
        EN_NACK = 5
    } enable_e;

    // Write-1-to-clear bit positions in the clear register
    localparam int CLR_STOP_BIT = 0;
    localparam int CLR_ADDR_BIT = 1;
    localparam int CLR_NACK_BIT = 2;

    typedef enum logic [REG_AW-1:0] {
        RS_ENABLE = 3'd0,
        RS_CMD    = 3'd1,
        RS_CLEAR  = 3'd2,
        RS_STATUS = 3'd3,
        RS_RXDATA = 3'd4,
        RS_TXDATA = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic              rd;
        logic              wr;
        logic [REG_AW-1:0] sel;
        logic [BUS_DW-1:0] data;
    } bus_req_t;

    // Spread the enable bits over the flag positions; one bit covers two flags
    function automatic logic [NUM_FLAGS-1:0] expand_enables(input logic [NUM_EN-1:0] en);
        logic [NUM_FLAGS-1:0] m;
        m            = '0;
        m[FL_RX]     = en[EN_RX];
        m[FL_TX]     = en[EN_TX];
        m[FL_STOP]   = en[EN_STOP];
        m[FL_RELOAD] = en[EN_TC];
        m[FL_DONE]   = en[EN_TC];
        m[FL_ADDR]   = en[EN_ADDR];
        m[FL_NACK]   = en[EN_NACK];
        return m;
    endfunction

    function automatic logic is_write_to(input bus_req_t r, input reg_sel_e s);
        return r.wr && (r.sel == s);
    endfunction

    function automatic logic is_read_of(input bus_req_t r, input reg_sel_e s);
        return r.rd && (r.sel == s);
    endfunction

endpackage

// File: rtl/i2c_evt_decode.sv
module i2c_evt_decode
    import i2c_evt_pkg::*;
(
    input  bus_req_t             req,
    output logic [NUM_FLAGS-1:0] clr,
    output logic                 en_wr,
    output logic                 tx_wr
);

    logic cmd_wr;
    logic clr_wr;
    logic count_nonzero;
    logic cmd_start_stop;

    assign cmd_wr         = is_write_to(req, RS_CMD);
    assign clr_wr         = is_write_to(req, RS_CLEAR);
    assign count_nonzero  = |req.data[COUNT_W-1:0];
    assign cmd_start_stop = req.data[CMD_START_BIT] | req.data[CMD_STOP_BIT];

    always_comb begin
        clr            = '0;
        clr[FL_RX]     = is_read_of(req, RS_RXDATA);
        clr[FL_TX]     = is_write_to(req, RS_TXDATA);
        clr[FL_STOP]   = clr_wr && req.data[CLR_STOP_BIT];
        clr[FL_RELOAD] = cmd_wr && count_nonzero;
        clr[FL_DONE]   = cmd_wr && cmd_start_stop;
        clr[FL_ADDR]   = clr_wr && req.data[CLR_ADDR_BIT];
        clr[FL_NACK]   = clr_wr && req.data[CLR_NACK_BIT];
    end

    assign en_wr = is_write_to(req, RS_ENABLE);
    assign tx_wr = is_write_to(req, RS_TXDATA);

endmodule

// File: rtl/i2c_evt_flags.sv
module i2c_evt_flags #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o
);

    for (genvar i = 0; i < N; i++) begin : g_cell
        logic bit_q;
        // Set has priority over clear so a same-cycle event is never lost
        always_ff @(posedge clk) begin
            if (rst) begin
                bit_q <= 1'b0;
            end else if (set_i[i]) begin
                bit_q <= 1'b1;
            end else if (clr_i[i]) begin
                bit_q <= 1'b0;
            end
        end
        assign flags_o[i] = bit_q;
    end

endmodule

// File: rtl/i2c_evt_irq_gen.sv
module i2c_evt_irq_gen
    import i2c_evt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en_wr,
    input  logic [NUM_EN-1:0]    en_wdata,
    input  logic [NUM_FLAGS-1:0] flags,
    output logic [NUM_EN-1:0]    en_o,
    output logic                 irq_o
);

    logic [NUM_EN-1:0]    en_q;
    logic [NUM_FLAGS-1:0] mask;
    logic                 irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (en_wr) begin
            en_q <= en_wdata;
        end
    end

    assign mask = expand_enables(en_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |(flags & mask);
        end
    end

    assign en_o  = en_q;
    assign irq_o = irq_q;

endmodule

// File: rtl/i2c_evt_irq.sv
module i2c_evt_irq
    import i2c_evt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_FLAGS-1:0] evt_i,
    input  logic                 reg_en,
    input  logic                 reg_we,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic [BUS_DW-1:0]    reg_wdata,
    output logic [BUS_DW-1:0]    reg_rdata,
    input  logic [BYTE_W-1:0]    rx_data_i,
    output logic [BYTE_W-1:0]    tx_data_o,
    output logic                 tx_wr_o,
    output logic                 rx_dma_req_o,
    output logic                 irq_o
);

    bus_req_t             req;
    logic [NUM_FLAGS-1:0] clr;
    logic                 en_wr;
    logic                 tx_wr;
    logic [NUM_FLAGS-1:0] status_q;
    logic [NUM_EN-1:0]    en_q;
    logic [BYTE_W-1:0]    tx_data_q;
    logic                 tx_wr_q;

    always_comb begin
        req.rd   = reg_en & ~reg_we;
        req.wr   = reg_en & reg_we;
        req.sel  = reg_addr;
        req.data = reg_wdata;
    end

    i2c_evt_decode i_decode (
        .req   (req),
        .clr   (clr),
        .en_wr (en_wr),
        .tx_wr (tx_wr)
    );

    i2c_evt_flags #(.N(NUM_FLAGS)) i_flags (
        .clk     (clk),
        .rst     (rst),
        .set_i   (evt_i),
        .clr_i   (clr),
        .flags_o (status_q)
    );

    i2c_evt_irq_gen i_irq (
        .clk      (clk),
        .rst      (rst),
        .en_wr    (en_wr),
        .en_wdata (reg_wdata[NUM_EN-1:0]),
        .flags    (status_q),
        .en_o     (en_q),
        .irq_o    (irq_o)
    );

    // Transmit byte hand-off to the engine
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_wr_q   <= 1'b0;
            tx_data_q <= '0;
        end else begin
            tx_wr_q <= tx_wr;
            if (tx_wr) begin
                tx_data_q <= reg_wdata[BYTE_W-1:0];
            end
        end
    end

    // Read mux: status read has no side effect; rx data read clears via decoder
    always_comb begin
        unique case (reg_addr)
            RS_ENABLE: reg_rdata = BUS_DW'(en_q);
            RS_STATUS: reg_rdata = BUS_DW'(status_q);
            RS_RXDATA: reg_rdata = BUS_DW'(rx_data_i);
            default:   reg_rdata = '0;
        endcase
    end

    assign tx_data_o    = tx_data_q;
    assign tx_wr_o      = tx_wr_q;
    assign rx_dma_req_o = status_q[FL_RX];

endmodule

// File: rtl/i2c_evt_irq_chk.sv
module i2c_evt_irq_chk
    import i2c_evt_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_FLAGS-1:0] evt_i,
    input logic                 reg_en,
    input logic                 reg_we,
    input logic [REG_AW-1:0]    reg_addr,
    input logic [BUS_DW-1:0]    reg_wdata,
    input logic [NUM_FLAGS-1:0] status_q,
    input logic [NUM_EN-1:0]    en_q,
    input logic                 irq_o,
    input logic                 rx_dma_req_o,
    input logic                 tx_wr_o
);

    logic wr_any;
    logic rd_any;
    assign wr_any = reg_en && reg_we;
    assign rd_any = reg_en && !reg_we;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (status_q == '0 && en_q == '0 && !irq_o && !tx_wr_o));

    // Covers R10 as well: the set wins even when a clear arrives with it
    assert_event_sets_R2: assert property (@(posedge clk) disable iff (rst)
        (|evt_i) |=> ((status_q & $past(evt_i)) == $past(evt_i)));

    assert_status_read_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_any && reg_addr == RS_STATUS && evt_i == '0) |=> $stable(status_q));

    assert_rx_read_clears_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_any && reg_addr == RS_RXDATA && !evt_i[FL_RX]) |=> !status_q[FL_RX]);

    assert_tx_write_clears_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_any && reg_addr == RS_TXDATA && !evt_i[FL_TX]) |=> (!status_q[FL_TX] && tx_wr_o));

    assert_zero_count_keeps_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_any && reg_addr == RS_CMD && reg_wdata[COUNT_W-1:0] == '0 && status_q[FL_RELOAD])
        |=> status_q[FL_RELOAD]);

    assert_cmd_clears_done_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_any && reg_addr == RS_CMD && (reg_wdata[CMD_START_BIT] || reg_wdata[CMD_STOP_BIT])
         && !evt_i[FL_DONE]) |=> !status_q[FL_DONE]);

    assert_irq_follows_R9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_o == $past(|(status_q & expand_enables(en_q)))));

    assert_dma_request_R11: assert property (@(posedge clk) disable iff (rst)
        evt_i[FL_RX] |=> rx_dma_req_o);

endmodule

bind i2c_evt_irq i2c_evt_irq_chk i_chk (
    .clk          (clk),
    .rst          (rst),
    .evt_i        (evt_i),
    .reg_en       (reg_en),
    .reg_we       (reg_we),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .status_q     (status_q),
    .en_q         (en_q),
    .irq_o        (irq_o),
    .rx_dma_req_o (rx_dma_req_o),
    .tx_wr_o      (tx_wr_o)
);

// File: tb/test_i2c_evt_irq.sv
module test_i2c_evt_irq;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] evt_i = '0;
    logic       reg_en = 1'b0;
    logic       reg_we = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [9:0] reg_wdata = '0;
    logic [9:0] reg_rdata;
    logic [7:0] rx_data_i = '0;
    logic [7:0] tx_data_o;
    logic       tx_wr_o;
    logic       rx_dma_req_o;
    logic       irq_o;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    always #2 clk = ~clk;

    i2c_evt_irq i_i2c_evt_irq (
        .clk          (clk),
        .rst          (rst),
        .evt_i        (evt_i),
        .reg_en       (reg_en),
        .reg_we       (reg_we),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .rx_data_i    (rx_data_i),
        .tx_data_o    (tx_data_o),
        .tx_wr_o      (tx_wr_o),
        .rx_dma_req_o (rx_dma_req_o),
        .irq_o        (irq_o)
    );

    // op: 0 none, 1 write, 2 read | addr | wdata | events | expected status | expected irq
    localparam int NV = 24;
    localparam logic [29:0] VEC [NV] = '{
        {2'd0, 3'd0, 10'h000, 7'h01, 7'h01, 1'b0}, // R2 rx event
        {2'd1, 3'd0, 10'h001, 7'h00, 7'h01, 1'b1}, // R8 R9 rx enable
        {2'd2, 3'd4, 10'h000, 7'h00, 7'h00, 1'b0}, // R3 R9 rx read clears
        {2'd0, 3'd0, 10'h000, 7'h02, 7'h02, 1'b0}, // R2 tx event, masked
        {2'd1, 3'd5, 10'h05A, 7'h00, 7'h00, 1'b0}, // R4 tx write clears
        {2'd0, 3'd0, 10'h000, 7'h64, 7'h64, 1'b0}, // R2 stop, addr, nack
        {2'd1, 3'd0, 10'h034, 7'h00, 7'h64, 1'b1}, // R8 enable those three
        {2'd1, 3'd2, 10'h000, 7'h00, 7'h64, 1'b1}, // R5 zeros no effect
        {2'd1, 3'd2, 10'h001, 7'h00, 7'h60, 1'b1}, // R5 stop clear
        {2'd1, 3'd2, 10'h002, 7'h00, 7'h40, 1'b1}, // R5 addr clear
        {2'd1, 3'd2, 10'h004, 7'h00, 7'h00, 1'b0}, // R5 nack clear
        {2'd0, 3'd0, 10'h000, 7'h18, 7'h18, 1'b0}, // R2 reload, done
        {2'd1, 3'd0, 10'h008, 7'h00, 7'h18, 1'b1}, // R8 shared enable
        {2'd1, 3'd1, 10'h000, 7'h00, 7'h18, 1'b1}, // R6 zero count keeps
        {2'd1, 3'd1, 10'h005, 7'h00, 7'h10, 1'b1}, // R6 nonzero count clears
        {2'd1, 3'd1, 10'h100, 7'h00, 7'h00, 1'b0}, // R7 start clears done
        {2'd0, 3'd0, 10'h000, 7'h10, 7'h10, 1'b1}, // R9 done alone raises irq
        {2'd1, 3'd1, 10'h200, 7'h00, 7'h00, 1'b0}, // R7 stop clears done
        {2'd1, 3'd1, 10'h200, 7'h10, 7'h10, 1'b1}, // R10 set beats stop cmd
        {2'd2, 3'd4, 10'h000, 7'h01, 7'h11, 1'b1}, // R10 set beats rx read
        {2'd1, 3'd0, 10'h000, 7'h00, 7'h11, 1'b0}, // R9 enables off
        {2'd2, 3'd3, 10'h000, 7'h00, 7'h11, 1'b0}, // R2 status read quiet
        {2'd2, 3'd4, 10'h000, 7'h00, 7'h10, 1'b0}, // R3 second rx read
        {2'd1, 3'd1, 10'h3FF, 7'h00, 7'h00, 1'b0}  // R7 start+stop+count
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bus_idle();
        reg_en = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; evt_i = '0;
    endtask

    task automatic read_now(input logic [2:0] a, output logic [9:0] d);
        reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic write_cycle(input logic [2:0] a, input logic [9:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        bus_idle();
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #800000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        logic [9:0] d;
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        check("R1 irq", irq_o, 1'b0);
        check("R1 tx_wr", tx_wr_o, 1'b0);
        check("R1 dma", rx_dma_req_o, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        read_now(3'd3, d); check("R1 status", d, 10'h000);
        read_now(3'd0, d); check("R1 enable", d, 10'h000);
        bus_idle();

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            logic [29:0] v;
            v = VEC[i];
            @(negedge clk);
            evt_i     = v[14:8];
            reg_addr  = v[27:25];
            reg_wdata = v[24:15];
            reg_en    = (v[29:28] != 2'd0);
            reg_we    = (v[29:28] == 2'd1);
            @(negedge clk);
            bus_idle();
            read_now(3'd3, d);
            check($sformatf("step %0d status", i), d, {3'b000, v[7:1]});
            @(negedge clk);
            bus_idle();
            #1 check($sformatf("step %0d irq", i), irq_o, v[0]);
        end

        // R3: rx data appears on a read of address 4
        rx_data_i = 8'h3C;
        @(negedge clk);
        read_now(3'd4, d); check("R3 rx data", d, 10'h03C);
        @(negedge clk);
        bus_idle();

        // R4: transmit byte hand-off and one-cycle strobe
        write_cycle(3'd5, 10'h0A5);
        #1 check("R4 tx strobe", tx_wr_o, 1'b1);
        check("R4 tx data", tx_data_o, 8'hA5);
        @(negedge clk);
        #1 check("R4 strobe one cycle", tx_wr_o, 1'b0);

        // R8: enable readback keeps bits 5:0 only
        write_cycle(3'd0, 10'h3FF);
        read_now(3'd0, d); check("R8 enable readback", d, 10'h03F);
        bus_idle();
        write_cycle(3'd0, 10'h000);

        // R11: dma request with rx enable off, removed by rx read
        @(negedge clk); evt_i = 7'h01;
        @(negedge clk); evt_i = 7'h00;
        #1 check("R11 dma set", rx_dma_req_o, 1'b1);
        check("R11 irq masked", irq_o, 1'b0);
        @(negedge clk); read_now(3'd4, d);
        @(negedge clk); bus_idle();
        #1 check("R11 dma cleared", rx_dma_req_o, 1'b0);

        // R9: one-cycle delay from an enable write to irq
        @(negedge clk); evt_i = 7'h40;
        @(negedge clk); evt_i = 7'h00;
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 10'h020;
        @(negedge clk); bus_idle();
        #1 check("R9 irq not yet", irq_o, 1'b0);
        @(negedge clk);
        #1 check("R9 irq raised", irq_o, 1'b1);

        // R1: reset in mid-run clears everything
        @(negedge clk); evt_i = 7'h7F;
        @(negedge clk); evt_i = 7'h00;
        rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        #1 check("R1 irq after reset", irq_o, 1'b0);
        check("R1 dma after reset", rx_dma_req_o, 1'b0);
        read_now(3'd3, d); check("R1 status after reset", d, 10'h000);
        read_now(3'd0, d); check("R1 enable after reset", d, 10'h000);
        bus_idle();

        repeat (2) @(negedge clk);
        summary();
    end

endmodule